// File: doc/BRIEF.md
# Conversion start and trigger controller

This block decides when an analog-to-digital conversion runs. Software can request a single conversion through a start write. Alternatively, with automatic triggering enabled, a rising edge on one of eight selectable sources launches a conversion. Selection 0 is the block's own completion flag, and selections 1 to 7 are external trigger lines. A conversion started by a trigger edge first zeroes the converter clock prescaler, so conversions launched at fixed intervals line up with the prescaled clock.

The conversion is modelled as a busy period of exactly 13 prescaled clock periods. The start bit stays high for the whole busy period. A channel number written during a conversion waits until that conversion has finished. Every conversion ends by setting a completion flag. Software clears the flag by writing a one, and the flag gates an interrupt output. When the flag is the selected trigger source, each completion starts the next conversion, which gives free-running operation for as long as software keeps clearing the flag.

Top module: `adc_start_ctrl`

## Requirements
- R1: A one-cycle `start_wr` pulse while idle and with `pwr_down` low raises `start_bit` in the following cycle. With `pwr_down` high the write does nothing. A software-started conversion ends between 12*D+1 and 13*D cycles after `start_bit` rises, where D is the division ratio from R9.
- R2: `start_bit` stays high until the conversion completes and is cleared by hardware at completion. A triggered conversion keeps it high for exactly 13*D cycles.
- R3: A channel written with `chan_wr` while idle appears on `chan_active` in the next cycle. A channel written during a conversion leaves `chan_active` unchanged until the cycle after `start_bit` falls.
- R4: With `auto_en` high, `trig_sel` = k (1..7) picks `ext_trig[k-1]`. A low-to-high change of that line between two clock samples starts a conversion in the next cycle and zeroes the prescaler.
- R5: A trigger edge during a busy conversion neither restarts nor lengthens it. A trigger line still high at completion starts no further conversion.
- R6: `done_flag` is set at the end of every conversion, whatever `irq_en` and `glob_irq_en` are. `irq` equals `done_flag` AND `irq_en` AND `glob_irq_en`.
- R7: A `flag_clr` pulse clears `done_flag` in the next cycle. If a conversion completes in the same cycle, the flag ends up set.
- R8: With `trig_sel` = 0 and `auto_en` high, the completion flag is the trigger source. The first conversion needs a software start. Each completion that raises the flag starts the next conversion one cycle later. The chain stops at the first completion that finds the flag already set.
- R9: `presc_sel` = 0 and 1 both give D = 2. `presc_sel` = s in 2..7 gives D = 2^s. The ratio is captured when a conversion starts.
- R10: With `auto_en` low, trigger edges start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Converter power-down; blocks all starts while high |
| start_wr | input | 1 | Software write of one to the start bit |
| auto_en | input | 1 | Enables automatic triggering |
| trig_sel | input | 3 | Trigger source select (0 = own completion flag) |
| ext_trig | input | 7 | External trigger lines for selections 1..7 |
| presc_sel | input | 3 | Prescaler division select |
| chan_wr | input | 1 | Channel write strobe |
| chan_wdata | input | 3 | Channel number being written |
| flag_clr | input | 1 | Write one to clear the completion flag |
| irq_en | input | 1 | Completion interrupt enable |
| glob_irq_en | input | 1 | Global interrupt enable |
| start_bit | output | 1 | High while a conversion is busy |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| chan_active | output | 3 | Channel used by the current or next conversion |

## Verification
The assertions assume that `trig_sel` and `presc_sel` change only while the selected source is low and the block is idle. A select change at any other time could produce a false edge that no check anticipates. The stimulus changes both selects only during setup cycles, in which the external lines are held low and the flag has just been cleared. Every input changes on the falling clock edge, so the sampled edges are clean single-cycle transitions, and the exact 13*D timing of triggered conversions can be predicted.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion start controller.
// Assumes nothing beyond a single clock domain.
package adc_seq_pkg;

    // Sequencer state: waiting for a start, or counting prescaled ticks.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // Start requests that may launch a conversion in one cycle.
    typedef struct packed {
        logic by_sw;
        logic by_trig;
    } start_req_t;

endpackage

// File: rtl/adc_prescaler.sv
// Free-running prescaler producing one tick every D system cycles.
// D is 2 for select 0 or 1, and 2^sel otherwise. The select is captured
// on load_sel so that a conversion keeps one ratio. restart zeroes the count.
// Assumes restart and load_sel are single-cycle strobes from the sequencer.
module adc_prescaler #(
    parameter int unsigned PSEL_W = 3,
    localparam int unsigned CNT_W = (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              load_sel,
    input  logic [PSEL_W-1:0] psel_in,
    output logic              tick
);

    logic [CNT_W-1:0]  cnt_q;
    logic [PSEL_W-1:0] psel_q;
    logic [CNT_W-1:0]  mask;
    int                shift;

    // Count system cycles; a triggered start forces the count back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Capture the ratio select at every conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel_q <= '0;
        end else if (load_sel) begin
            psel_q <= psel_in;
        end
    end

    // Build a mask of the low count bits that must all be one for a tick.
    always_comb begin
        shift = (psel_q == '0) ? 1 : int'(psel_q);
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < shift);
        end
    end

    // Tick on the last cycle of each prescaled period.
    assign tick = ((cnt_q & mask) == mask);

    // R4: a prescaler reset can never be followed at once by a tick
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/adc_trig_select.sv
// Trigger source multiplexer and rising-edge detector on the system clock.
// Source 0 is the block's own completion flag; sources 1..N-1 are external.
// Assumes the select changes only while the selected source is low.
module adc_trig_select #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-2:0] ext_src,
    input  logic             self_flag,
    output logic             rise
);

    logic [N_SRC-1:0] src_vec;
    logic             sel_now;
    logic             sel_prev_q;

    // Gather the flag and the external lines into one indexable vector.
    assign src_vec = {ext_src, self_flag};
    assign sel_now = src_vec[sel];

    // Remember the previous level of the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev_q <= 1'b0;
        end else begin
            sel_prev_q <= sel_now;
        end
    end

    // A rising edge is high now after low in the previous cycle.
    assign rise = sel_now & ~sel_prev_q;

    // R5: an edge is reported once, never on two cycles in a row
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: accepts software or trigger starts while idle,
// counts CONV_TICKS prescaled ticks, then ends the busy period and sets
// the completion flag. A set in the same cycle as a clear wins.
// Assumes tick comes from a prescaler restarted by start_trig.
module adc_conv_seq #(
    parameter int unsigned CONV_TICKS = 13,
    localparam int unsigned TC_W = $clog2(CONV_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic sw_start,
    input  logic auto_en,
    input  logic trig_rise,
    input  logic tick,
    input  logic flag_clr,
    output logic busy,
    output logic flag,
    output logic start_trig,
    output logic start_any
);
    import adc_seq_pkg::*;

    seq_state_e     state_q;
    logic [TC_W-1:0] tick_cnt_q;
    logic           complete;
    logic           flag_q;
    start_req_t     req;

    // Qualify both start sources: idle and powered only.
    always_comb begin
        req.by_sw   = sw_start & ~pwr_down & (state_q == SEQ_IDLE);
        req.by_trig = auto_en & trig_rise & ~pwr_down & (state_q == SEQ_IDLE);
    end

    assign start_trig = req.by_trig;
    assign start_any  = req.by_sw | req.by_trig;
    assign busy       = (state_q == SEQ_BUSY);
    assign complete   = busy & tick & (tick_cnt_q == TC_W'(CONV_TICKS - 1));

    // Move between idle and busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (start_any) begin
            state_q <= SEQ_BUSY;
        end else if (complete) begin
            state_q <= SEQ_IDLE;
        end
    end

    // Count prescaled ticks within a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (start_any || complete) begin
            tick_cnt_q <= '0;
        end else if (busy && tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // Completion flag: set at the end of each conversion, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (complete) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !complete |=> busy);

    // R5
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trig_rise && !complete |=> tick_cnt_q >= $past(tick_cnt_q));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> flag);

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !complete |=> !flag);

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt_q < TC_W'(CONV_TICKS));

endmodule

// File: rtl/adc_start_ctrl.sv
// Top of the conversion start and trigger controller. It ties the trigger
// selector, the prescaler and the sequencer together, holds the channel
// pending until the converter is idle, and gates the interrupt.
// Assumes trig_sel and presc_sel change only between conversions.
module adc_start_ctrl #(
    parameter int unsigned N_TRIG     = 8,
    parameter int unsigned PSEL_W     = 3,
    parameter int unsigned CH_W       = 3,
    parameter int unsigned CONV_TICKS = 13,
    localparam int unsigned TSEL_W    = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              start_wr,
    input  logic              auto_en,
    input  logic [TSEL_W-1:0] trig_sel,
    input  logic [N_TRIG-2:0] ext_trig,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              chan_wr,
    input  logic [CH_W-1:0]   chan_wdata,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              glob_irq_en,
    output logic              start_bit,
    output logic              done_flag,
    output logic              irq,
    output logic [CH_W-1:0]   chan_active
);

    logic            trig_rise;
    logic            tick;
    logic            busy;
    logic            flag;
    logic            start_trig;
    logic            start_any;
    logic [CH_W-1:0] chan_pend_q;
    logic [CH_W-1:0] chan_next;
    logic [CH_W-1:0] chan_act_q;

    adc_trig_select #(.N_SRC(N_TRIG)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (trig_sel),
        .ext_src   (ext_trig),
        .self_flag (flag),
        .rise      (trig_rise)
    );

    adc_prescaler #(.PSEL_W(PSEL_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_trig),
        .load_sel (start_any),
        .psel_in  (presc_sel),
        .tick     (tick)
    );

    adc_conv_seq #(.CONV_TICKS(CONV_TICKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .sw_start   (start_wr),
        .auto_en    (auto_en),
        .trig_rise  (trig_rise),
        .tick       (tick),
        .flag_clr   (flag_clr),
        .busy       (busy),
        .flag       (flag),
        .start_trig (start_trig),
        .start_any  (start_any)
    );

    // Newest channel value, including a write in this very cycle.
    assign chan_next = chan_wr ? chan_wdata : chan_pend_q;

    // Hold the last written channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_pend_q <= '0;
        end else begin
            chan_pend_q <= chan_next;
        end
    end

    // Pass the pending channel to the converter only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_act_q <= '0;
        end else if (!busy) begin
            chan_act_q <= chan_next;
        end
    end

    assign start_bit   = busy;
    assign done_flag   = flag;
    assign chan_active = chan_act_q;
    assign irq         = flag & irq_en & glob_irq_en;

    // R3
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |=> $stable(chan_active));

    // R1
    pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_bit && pwr_down |=> !start_bit);

endmodule

// File: tb/adc_start_ctrl_bench.sv
module adc_start_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_down, start_wr, auto_en;
    logic [2:0] trig_sel;
    logic [6:0] ext_trig;
    logic [2:0] presc_sel;
    logic       chan_wr;
    logic [2:0] chan_wdata;
    logic       flag_clr, irq_en, glob_irq_en;
    logic       start_bit, done_flag, irq;
    logic [2:0] chan_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_start_ctrl u_adc_start_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .start_wr(start_wr),
        .auto_en(auto_en), .trig_sel(trig_sel), .ext_trig(ext_trig),
        .presc_sel(presc_sel), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
        .flag_clr(flag_clr), .irq_en(irq_en), .glob_irq_en(glob_irq_en),
        .start_bit(start_bit), .done_flag(done_flag), .irq(irq),
        .chan_active(chan_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input int ps);
        return (ps < 2) ? 2 : (1 << ps);
    endfunction

    // Reset values of every output.
    task automatic t_reset();
        rst_n = 1'b0; pwr_down = 0; start_wr = 0; auto_en = 0; trig_sel = 0;
        ext_trig = '0; presc_sel = 0; chan_wr = 0; chan_wdata = 0;
        flag_clr = 0; irq_en = 0; glob_irq_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_bit == 0, "R2 reset start_bit", start_bit, 0);
        chk(done_flag == 0, "R6 reset done_flag", done_flag, 0);
        chk(irq == 0, "R6 reset irq", irq, 0);
        chk(chan_active == 0, "R3 reset chan_active", chan_active, 0);
    endtask

    // Triggered conversion with exact timing.
    // mode 0 plain, 1 clear at completion cycle, 2 glitch edge while busy, 3 channel write while busy
    task automatic trig_conv(input int ps, input int src, input int mode);
        int d = div_of(ps);
        @(negedge clk);
        flag_clr = 1; presc_sel = 3'(ps); trig_sel = 3'(src); auto_en = 1; ext_trig = '0;
        @(negedge clk);
        flag_clr = 0;
        @(negedge clk);
        ext_trig[src-1] = 1'b1;
        @(negedge clk);
        chk(start_bit == 1, "R4 triggered start", start_bit, 1);
        for (int j = 1; j < 13 * d; j++) begin
            @(negedge clk);
            if (j == 13 * d - 1) begin
                chk(start_bit == 1, "R2 R9 still busy at 13D-1", start_bit, 1);
                if (mode == 3) chk(chan_active == 5, "R3 channel held", chan_active, 5);
                if (mode == 1) flag_clr = 1;
            end
            if (mode == 2 && j == 3) ext_trig[src-1] = 1'b0;
            if (mode == 2 && j == 5) ext_trig[src-1] = 1'b1;
            if (mode == 3 && j == 4) begin chan_wr = 1; chan_wdata = 3'd2; end
            if (mode == 3 && j == 5) chan_wr = 0;
        end
        @(negedge clk);
        flag_clr = 0;
        chk(start_bit == 0, "R2 R9 cleared at 13D", start_bit, 0);
        chk(done_flag == 1, mode == 1 ? "R7 set beats clear" : "R6 flag set", done_flag, 1);
        if (mode == 2) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(start_bit == 0, "R5 held trigger no restart", start_bit, 0);
            end
        end
        if (mode == 3) begin
            chk(chan_active == 5, "R3 held at completion", chan_active, 5);
            @(negedge clk);
            chk(chan_active == 2, "R3 applied after", chan_active, 2);
        end
        ext_trig = '0;
        @(negedge clk);
    endtask

    task automatic t_sw_start();
        int d = div_of(2);
        int len = 0;
        @(negedge clk);
        auto_en = 0; presc_sel = 3'd2; pwr_down = 1; start_wr = 1;
        @(negedge clk);
        start_wr = 0;
        chk(start_bit == 0, "R1 power-down blocks start", start_bit, 0);
        pwr_down = 0; start_wr = 1;
        @(negedge clk);
        start_wr = 0;
        chk(start_bit == 1, "R1 software start", start_bit, 1);
        while (start_bit && len < 20 * d) begin
            @(negedge clk);
            len++;
        end
        chk(len >= 12 * d + 1 && len <= 13 * d, "R1 software length", len, 13 * d);
    endtask

    task automatic t_chan_idle();
        @(negedge clk);
        chan_wr = 1; chan_wdata = 3'd5;
        @(negedge clk);
        chan_wr = 0;
        chk(chan_active == 5, "R3 idle write", chan_active, 5);
    endtask

    task automatic t_irq();
        @(negedge clk);
        irq_en = 0; glob_irq_en = 1; #1;
        chk(irq == 0 && done_flag == 1, "R6 irq masked local", irq, 0);
        @(negedge clk);
        irq_en = 1; glob_irq_en = 0; #1;
        chk(irq == 0, "R6 irq masked global", irq, 0);
        @(negedge clk);
        glob_irq_en = 1; #1;
        chk(irq == 1, "R6 irq raised", irq, 1);
        @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk(done_flag == 0, "R7 write-one clears", done_flag, 0);
        irq_en = 0; glob_irq_en = 0;
    endtask

    task automatic t_no_auto();
        @(negedge clk);
        auto_en = 0; trig_sel = 3'd2; ext_trig = '0;
        @(negedge clk);
        ext_trig[1] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(start_bit == 0, "R10 no start without auto", start_bit, 0);
        end
        ext_trig = '0;
    endtask

    task automatic wait_idle(input int lim);
        for (int j = 0; j < lim; j++) begin
            if (!start_bit) break;
            @(negedge clk);
        end
    endtask

    task automatic t_free_run();
        @(negedge clk);
        presc_sel = 3'd1; trig_sel = 3'd0; auto_en = 1; flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        repeat (3) @(negedge clk);
        chk(start_bit == 0, "R8 no start before software", start_bit, 0);
        start_wr = 1;
        @(negedge clk);
        start_wr = 0;
        wait_idle(40);
        chk(done_flag == 1 && start_bit == 0, "R8 first completion", done_flag, 1);
        @(negedge clk);
        chk(start_bit == 1, "R8 second started", start_bit, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        wait_idle(40);
        chk(done_flag == 1, "R8 second completion", done_flag, 1);
        @(negedge clk);
        chk(start_bit == 1, "R8 third started", start_bit, 1);
        wait_idle(40);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(start_bit == 0, "R8 chain stops with flag set", start_bit, 0);
        end
        auto_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sw_start();
        trig_conv(0, 1, 0);
        trig_conv(3, 4, 0);
        trig_conv(7, 7, 0);
        trig_conv(1, 2, 1);
        trig_conv(1, 3, 2);
        t_chan_idle();
        trig_conv(0, 5, 3);
        t_irq();
        t_no_auto();
        t_free_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule